// File: doc/BRIEF.md
# Programmable Parallel Port Interface

This block sits on a simple synchronous register bus and gives a processor three 8-bit parallel ports, named A, B and C, plus a control register. The four registers take four consecutive addresses. Each port has pad-side input pins, an output latch and an output-enable vector, so the block can drive a bidirectional pad ring directly. Only the basic input/output mode is built. Strobed and bidirectional handshake modes are not part of this block.

Software writes a control word to set the port directions. When the top bit of the word is set, the word is a mode-set word. It chooses the direction of port A, port B and the two 4-bit halves of port C, and it clears every output latch. When the top bit is clear, the word sets or clears one selected bit of port C and leaves the other port C bits alone. After configuration, data moves by plain reads and writes to the port addresses. A read returns the pins of a port set as input, or the latch of a port set as output. Read data is registered and appears one clock after the read strobe is sampled.

Top module: `ppi_port_top`

## Requirements
- R1: After reset every port is an input: all three output-enable vectors are 0x00, all output latches are 0x00 and rdata is 0x00.
- R2: A control write (address 3) with bit 7 set sets the directions from these bits: bit 4 for port A, bit 3 for upper port C (bits 7:4), bit 1 for port B and bit 0 for lower port C (bits 3:0). A 1 means input and a 0 means output. Each output-enable vector is 0xFF for an output port or half and 0x00 for an input, per nibble on port C.
- R3: Control word 0x92 makes ports A and B inputs and both halves of port C outputs: pa_oe=0x00, pb_oe=0x00, pc_oe=0xFF.
- R4: A mode-set write clears the output latches of ports A, B and C to 0x00 on the next clock.
- R5: A write to a port address (0 = A, 1 = B, 2 = C) loads that port's latch, which appears on its output pins on the next clock. Reading an output port returns its latch.
- R6: Reading a port configured as input returns the value on its input pins.
- R7: A write to a port configured as input still updates its latch (visible on the pad output vector) but its output enable stays 0x00.
- R8: A control write with bit 7 clear picks port C bit wdata[3:1] and loads it with wdata[0] (1 sets, 0 clears). The other seven port C latch bits stay unchanged.
- R9: Reading the control address returns 0xFF.
- R10: Reading port C gives pins for each half configured as input and latch bits for each half configured as output.
- R11: A bit set/reset word leaves every direction unchanged. In a mode-set word, bits 6:5 and bit 2 (group mode fields) have no effect, and every group works in basic mode.
- R12: rdata is loaded one clock after a sampled read strobe and holds its value while rd_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr | input | 2 | Register offset: 0 A, 1 B, 2 C, 3 control |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, one cycle per read |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| pa_in | input | 8 | Port A input pins |
| pa_out | output | 8 | Port A output latch |
| pa_oe | output | 8 | Port A output enable |
| pb_in | input | 8 | Port B input pins |
| pb_out | output | 8 | Port B output latch |
| pb_oe | output | 8 | Port B output enable |
| pc_in | input | 8 | Port C input pins |
| pc_out | output | 8 | Port C output latch |
| pc_oe | output | 8 | Port C output enable, per half |

## Verification
The hardest case to reach is a port C read where one half is an input and the other an output. Each half must return data from a different source, and the mode-set write that creates this split also clears the latch. The stimulus first writes mode-set word 0x88, then loads port C with a known pattern while different values sit on the pins, and then reads port C. The result shows which nibble comes from the pins and which from the latch. A write to input port A before any direction change shows that the latch updates while the port stays undriven. Mode words with the group-mode bits set show that those fields are ignored.

// File: rtl/ppi_pkg.sv
package ppi_pkg;
  localparam int unsigned PORT_W  = 8;
  localparam int unsigned ADDR_W  = 2;
  localparam int unsigned BITSEL_W = $clog2(PORT_W);
  localparam int unsigned HALF_W  = PORT_W / 2;

  localparam logic [ADDR_W-1:0] OFS_A    = 2'd0;
  localparam logic [ADDR_W-1:0] OFS_B    = 2'd1;
  localparam logic [ADDR_W-1:0] OFS_C    = 2'd2;
  localparam logic [ADDR_W-1:0] OFS_CTRL = 2'd3;

  localparam int unsigned CW_KIND_BIT = 7;
  localparam int unsigned CW_A_BIT    = 4;
  localparam int unsigned CW_CU_BIT   = 3;
  localparam int unsigned CW_B_BIT    = 1;
  localparam int unsigned CW_CL_BIT   = 0;

  localparam logic [PORT_W-1:0] CTRL_READ_VAL = '1;

  typedef struct packed {
    logic a_in;
    logic b_in;
    logic cu_in;
    logic cl_in;
  } dir_t;

  localparam dir_t DIR_RESET = '{a_in: 1'b1, b_in: 1'b1, cu_in: 1'b1, cl_in: 1'b1};
endpackage

// File: rtl/ppi_reset_sync.sv
module ppi_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= stage_d;
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/ppi_ctrl.sv
module ppi_ctrl
  import ppi_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [PORT_W-1:0]   wdata,
  output dir_t                dirs,
  output logic                mode_wr,
  output logic                bsr_wr,
  output logic [BITSEL_W-1:0] bsr_idx,
  output logic                bsr_val
);
  logic ctrl_sel;
  dir_t dirs_q;
  dir_t dirs_d;
  logic dirs_en;

  always_comb begin
    ctrl_sel = wr_en && (addr == OFS_CTRL);
    mode_wr  = ctrl_sel &&  wdata[CW_KIND_BIT];
    bsr_wr   = ctrl_sel && !wdata[CW_KIND_BIT];
    bsr_idx  = wdata[BITSEL_W:1];
    bsr_val  = wdata[0];
  end

  always_comb begin
    dirs_en = mode_wr;
    dirs_d.a_in  = wdata[CW_A_BIT];
    dirs_d.b_in  = wdata[CW_B_BIT];
    dirs_d.cu_in = wdata[CW_CU_BIT];
    dirs_d.cl_in = wdata[CW_CL_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       dirs_q <= DIR_RESET;
    else if (dirs_en) dirs_q <= dirs_d;
  end

  assign dirs = dirs_q;
endmodule

// File: rtl/ppi_latch.sv
module ppi_latch #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         wr,
  input  logic [W-1:0] din,
  output logic [W-1:0] q
);
  logic [W-1:0] q_r;
  logic [W-1:0] q_d;
  logic         q_en;

  always_comb begin
    q_en = clr || wr;
    q_d  = clr ? '0 : din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_r <= '0;
    else if (q_en) q_r <= q_d;
  end

  assign q = q_r;
endmodule

// File: rtl/ppi_portc_latch.sv
module ppi_portc_latch
  import ppi_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                wr,
  input  logic [PORT_W-1:0]   din,
  input  logic                bsr_wr,
  input  logic [BITSEL_W-1:0] bsr_idx,
  input  logic                bsr_val,
  output logic [PORT_W-1:0]   q
);
  logic [PORT_W-1:0] q_r;
  logic [PORT_W-1:0] q_d;
  logic              q_en;

  always_comb begin
    q_en = clr || wr || bsr_wr;
    q_d  = q_r;
    if (clr) begin
      q_d = '0;
    end else if (wr) begin
      q_d = din;
    end else if (bsr_wr) begin
      for (int i = 0; i < int'(PORT_W); i++) begin
        if (BITSEL_W'(i) == bsr_idx) q_d[i] = bsr_val;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_r <= '0;
    else if (q_en) q_r <= q_d;
  end

  assign q = q_r;
endmodule

// File: rtl/ppi_read_path.sv
module ppi_read_path
  import ppi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  dir_t              dirs,
  input  logic [PORT_W-1:0] a_pins,
  input  logic [PORT_W-1:0] a_latch,
  input  logic [PORT_W-1:0] b_pins,
  input  logic [PORT_W-1:0] b_latch,
  input  logic [PORT_W-1:0] c_pins,
  input  logic [PORT_W-1:0] c_latch,
  output logic [PORT_W-1:0] rdata
);
  logic [PORT_W-1:0] c_in_mask;
  logic [PORT_W-1:0] a_view;
  logic [PORT_W-1:0] b_view;
  logic [PORT_W-1:0] c_view;
  logic [PORT_W-1:0] rd_d;
  logic [PORT_W-1:0] rd_q;

  always_comb begin
    c_in_mask = {{HALF_W{dirs.cu_in}}, {HALF_W{dirs.cl_in}}};
    a_view    = dirs.a_in ? a_pins : a_latch;
    b_view    = dirs.b_in ? b_pins : b_latch;
    c_view    = (c_pins & c_in_mask) | (c_latch & ~c_in_mask);
    unique case (addr)
      OFS_A:   rd_d = a_view;
      OFS_B:   rd_d = b_view;
      OFS_C:   rd_d = c_view;
      default: rd_d = CTRL_READ_VAL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_q <= '0;
    else if (rd_en) rd_q <= rd_d;
  end

  assign rdata = rd_q;
endmodule

// File: rtl/ppi_port_top.sv
module ppi_port_top
  import ppi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic [7:0]        pa_in,
  output logic [7:0]        pa_out,
  output logic [7:0]        pa_oe,
  input  logic [7:0]        pb_in,
  output logic [7:0]        pb_out,
  output logic [7:0]        pb_oe,
  input  logic [7:0]        pc_in,
  output logic [7:0]        pc_out,
  output logic [7:0]        pc_oe
);
  localparam int unsigned NUM_AB = 2;

  logic                rst_sync_n;
  dir_t                dirs;
  logic                mode_wr;
  logic                bsr_wr;
  logic [BITSEL_W-1:0] bsr_idx;
  logic                bsr_val;
  logic                c_wr;
  logic [PORT_W-1:0]   c_latch;
  logic [PORT_W-1:0]   ab_latch [NUM_AB];
  logic [NUM_AB-1:0]   ab_wr;
  logic [NUM_AB-1:0]   ab_in;

  ppi_reset_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ppi_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (wr_en),
    .addr    (addr),
    .wdata   (wdata),
    .dirs    (dirs),
    .mode_wr (mode_wr),
    .bsr_wr  (bsr_wr),
    .bsr_idx (bsr_idx),
    .bsr_val (bsr_val)
  );

  always_comb begin
    ab_wr[0] = wr_en && (addr == OFS_A);
    ab_wr[1] = wr_en && (addr == OFS_B);
    c_wr     = wr_en && (addr == OFS_C);
    ab_in[0] = dirs.a_in;
    ab_in[1] = dirs.b_in;
  end

  for (genvar g = 0; g < NUM_AB; g++) begin : g_ab
    ppi_latch #(.W(PORT_W)) u_latch (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .clr   (mode_wr),
      .wr    (ab_wr[g]),
      .din   (wdata),
      .q     (ab_latch[g])
    );
  end

  ppi_portc_latch u_c (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .clr     (mode_wr),
    .wr      (c_wr),
    .din     (wdata),
    .bsr_wr  (bsr_wr),
    .bsr_idx (bsr_idx),
    .bsr_val (bsr_val),
    .q       (c_latch)
  );

  ppi_read_path u_rd (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .rd_en   (rd_en),
    .addr    (addr),
    .dirs    (dirs),
    .a_pins  (pa_in),
    .a_latch (ab_latch[0]),
    .b_pins  (pb_in),
    .b_latch (ab_latch[1]),
    .c_pins  (pc_in),
    .c_latch (c_latch),
    .rdata   (rdata)
  );

  always_comb begin
    pa_out = ab_latch[0];
    pb_out = ab_latch[1];
    pc_out = c_latch;
    pa_oe  = {PORT_W{~ab_in[0]}};
    pb_oe  = {PORT_W{~ab_in[1]}};
    pc_oe  = {{HALF_W{~dirs.cu_in}}, {HALF_W{~dirs.cl_in}}};
  end
endmodule

// File: rtl/ppi_port_chk.sv
module ppi_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] addr,
  input logic       wr_en,
  input logic       rd_en,
  input logic [7:0] wdata,
  input logic [7:0] rdata,
  input logic [7:0] pa_out,
  input logic [7:0] pa_oe,
  input logic [7:0] pb_out,
  input logic [7:0] pb_oe,
  input logic [7:0] pc_out,
  input logic [7:0] pc_oe
);
  logic ctrl_wr;
  assign ctrl_wr = wr_en && (addr == 2'd3);

  a_r4_modeset_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && wdata[7]) |=> (pa_out == 8'h00 && pb_out == 8'h00 && pc_out == 8'h00));

  a_r8_bsr_target: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !wdata[7]) |=> (pc_out[$past(wdata[3:1])] == $past(wdata[0])));

  a_r8_bsr_others: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !wdata[7]) |=>
      (((pc_out ^ $past(pc_out)) & ~(8'h01 << $past(wdata[3:1]))) == 8'h00));

  a_r11_bsr_keeps_dirs: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !wdata[7]) |=> ($stable(pa_oe) && $stable(pb_oe) && $stable(pc_oe)));

  a_r7_input_write_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd0 && pa_oe == 8'h00) |=> (pa_oe == 8'h00 && pa_out == $past(wdata)));

  a_r9_ctrl_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 2'd3) |=> (rdata == 8'hFF));

  a_r12_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));
endmodule

bind ppi_port_top ppi_port_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_sync_n),
  .addr   (addr),
  .wr_en  (wr_en),
  .rd_en  (rd_en),
  .wdata  (wdata),
  .rdata  (rdata),
  .pa_out (pa_out),
  .pa_oe  (pa_oe),
  .pb_out (pb_out),
  .pb_oe  (pb_oe),
  .pc_out (pc_out),
  .pc_oe  (pc_oe)
);

// File: tb/test_ppi_port_top.sv
module test_ppi_port_top;
  logic       clk;
  logic       rst_n;
  logic [1:0] addr;
  logic       wr_en;
  logic       rd_en;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic [7:0] pa_in, pa_out, pa_oe;
  logic [7:0] pb_in, pb_out, pb_oe;
  logic [7:0] pc_in, pc_out, pc_oe;

  int checks;
  int errors;
  bit done;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  ppi_port_top i_ppi_port_top (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata),
    .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
    .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  // monitor: pops expected read data one cycle after a sampled read strobe
  initial begin
    forever begin
      @(posedge clk);
      if (rd_en === 1'b1) begin
        @(negedge clk);
        if (exp_q.size() == 0) begin
          check("R12 unexpected read", rdata, 8'hxx);
        end else begin
          check(tag_q.pop_front(), rdata, exp_q.pop_front());
        end
      end
    end
  end

  initial begin
    #100000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    checks = 0; errors = 0; done = 1'b0;
    addr = 2'd0; wr_en = 1'b0; rd_en = 1'b0; wdata = 8'h00;
    pa_in = 8'h5A; pb_in = 8'h3C; pc_in = 8'h00;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    check("R1 pa_oe", pa_oe, 8'h00);
    check("R1 pb_oe", pb_oe, 8'h00);
    check("R1 pc_oe", pc_oe, 8'h00);
    check("R1 pa_out", pa_out, 8'h00);
    check("R1 pc_out", pc_out, 8'h00);
    check("R1 rdata", rdata, 8'h00);

    bus_read(2'd0, 8'h5A, "R6 read A pins after reset");
    bus_read(2'd1, 8'h3C, "R6 read B pins after reset");

    // R7: write to input port A
    bus_write(2'd0, 8'h77);
    check("R7 pa_out latch", pa_out, 8'h77);
    check("R7 pa_oe stays off", pa_oe, 8'h00);
    bus_read(2'd0, 8'h5A, "R7 read A still pins");

    // R3 / R4: control word 0x92
    bus_write(2'd3, 8'h92);
    check("R3 pa_oe", pa_oe, 8'h00);
    check("R3 pb_oe", pb_oe, 8'h00);
    check("R3 pc_oe", pc_oe, 8'hFF);
    check("R4 pa_out cleared", pa_out, 8'h00);

    // R5 port C output
    bus_write(2'd2, 8'h3C);
    check("R5 pc_out", pc_out, 8'h3C);
    pc_in = 8'hC3;
    bus_read(2'd2, 8'h3C, "R5 read C latch");

    // R8 bit set/reset
    bus_write(2'd3, 8'h0F);
    check("R8 set bit7", pc_out, 8'hBC);
    bus_write(2'd3, 8'h04);
    check("R8 clear bit2", pc_out, 8'hB8);
    bus_write(2'd3, 8'h01);
    check("R8 set bit0", pc_out, 8'hB9);
    check("R11 bsr keeps pc_oe", pc_oe, 8'hFF);
    check("R11 bsr keeps pa_oe", pa_oe, 8'h00);

    bus_read(2'd3, 8'hFF, "R9 control read");

    // R12 hold
    pa_in = 8'h11;
    repeat (3) @(negedge clk);
    check("R12 rdata holds", rdata, 8'hFF);

    // R2 / R10: mode 0x88 -> A out, B out, C upper in, C lower out
    bus_write(2'd3, 8'h88);
    check("R2 pa_oe", pa_oe, 8'hFF);
    check("R2 pb_oe", pb_oe, 8'hFF);
    check("R2 pc_oe", pc_oe, 8'h0F);
    check("R4 pc_out cleared", pc_out, 8'h00);
    bus_write(2'd2, 8'h5E);
    pc_in = 8'hD6;
    bus_read(2'd2, 8'hDE, "R10 mixed C read");
    bus_write(2'd1, 8'h81);
    check("R5 pb_out", pb_out, 8'h81);
    bus_read(2'd1, 8'h81, "R5 read B latch");
    bus_read(2'd0, 8'h00, "R5 read A latch after clear");

    // R11 mode fields ignored
    bus_write(2'd3, 8'hE4);
    check("R11 pa_oe", pa_oe, 8'hFF);
    check("R11 pb_oe", pb_oe, 8'hFF);
    check("R11 pc_oe", pc_oe, 8'hFF);
    check("R4 pb_out cleared", pb_out, 8'h00);

    repeat (3) @(negedge clk);
    check("R12 queue drained", 8'(exp_q.size()), 8'h00);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule